// File: doc/BRIEF.md
# SCSI Bus-Free Arbitration Filter

This block decides when a SCSI device may take part in arbitration. It watches the BSY line that other devices drive. A filter counts clock cycles in which BSY stays inactive without a break, and it reports the bus as free once that count reaches a minimum time. Software sets an arbitration request bit. When the request bit is set, the bus is free and SEL is inactive, all in the same cycle, the block drives BSY and starts an arbitration-delay timer.

While the timer runs, the block reports that arbitration is in progress. When the timer expires, the block flags that the data bus may now be sampled to compare IDs. Software does that comparison. If SEL goes active during the wait, the block records that arbitration was lost. Clearing the request bit releases BSY and returns the block to idle.

Both minimum times are given in nanoseconds together with the clock period. The block converts each one to a whole number of cycles, rounding up. With the defaults (1200 ns free time, 2200 ns arbitration delay, 4 ns clock) this gives 300 and 550 cycles.

Top module: `scsi_arb_filter`

## Requirements
- R1: During reset and in the first cycle after it, `bsy_drive`, `bus_free`, `arb_in_progress`, `arb_sample_ok` and `arb_lost` are all 0.
- R2: `bus_free` goes to 1 after FREE_CYC consecutive rising edges with `bsy_in` = 0. FREE_CYC is the free time divided by the clock period, rounded up (300 at defaults). It stays 1 while `bsy_in` remains 0.
- R3: Any rising edge that samples `bsy_in` = 1 restarts the free count from zero, so `bus_free` is 0 in the following cycle.
- R4: `bsy_drive` rises only after an edge that sampled `arb_req` = 1, `bus_free` = 1 and `sel_in` = 0 together, with the block idle. If any one of the three is missing, the block stays idle.
- R5: After arbitration starts, `arb_in_progress` is 1 for exactly DELAY_CYC cycles (the delay time divided by the period, rounded up; 550 at defaults). Then `arb_sample_ok` is 1 until release, and `bsy_drive` stays 1 throughout.
- R6: An edge that samples `arb_req` = 0 returns the block to idle. In the next cycle `bsy_drive`, `arb_in_progress`, `arb_sample_ok` and `arb_lost` are all 0. Release takes priority over every other event in the same cycle.
- R7: An edge that samples `sel_in` = 1 while `arb_in_progress` = 1 and `arb_req` = 1 sets `arb_lost` from the next cycle. It stays set until release. This also holds on the edge where the delay expires. An edge that samples `sel_in` = 1 while the block is idle or in the sampling state leaves `arb_lost` unchanged.
- R8: `arb_in_progress` and `arb_sample_ok` are never both 1. `bsy_drive` equals their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsy_in | input | 1 | BSY as driven by other devices, 1 = active |
| sel_in | input | 1 | SEL line, 1 = active |
| arb_req | input | 1 | Arbitration request bit from the mode control |
| bsy_drive | output | 1 | Drive BSY onto the bus, 1 = assert |
| bus_free | output | 1 | Bus has been free for at least the minimum time |
| arb_in_progress | output | 1 | Arbitration delay is running |
| arb_sample_ok | output | 1 | Delay has elapsed; data bus may be sampled |
| arb_lost | output | 1 | SEL was seen during the arbitration wait |

## Verification
Two pairs of events can fall on the same edge. In the first, SEL goes active on exactly the edge where the delay timer expires. The bench schedules `sel_in` so that it is sampled on that edge, and expects both `arb_sample_ok` and `arb_lost` to be set in the next cycle. In the second, the request bit is dropped in the same cycle that SEL arrives during the wait. Here release must win, so `arb_lost` stays 0. The behavioural model settles both cases by the priorities stated in R6 and R7, and the bench compares every output against it in every cycle.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE   = 2'd0,
    ARB_WAIT   = 2'd1,
    ARB_SAMPLE = 2'd2
  } arb_state_e;

  // Whole clock cycles needed to cover a time in ns, rounded up.
  function automatic int unsigned ns_to_cycles(input int unsigned time_ns,
                                               input int unsigned period_ps);
    return (time_ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  // Counter width able to hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/arb_bus_free_filter.sv
module arb_bus_free_filter #(
  parameter int unsigned FREE_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bsy_in,
  output logic bus_free
);
  localparam int unsigned W = scsi_arb_pkg::cnt_width(FREE_CYC);

  logic [W-1:0] idle_cnt;
  logic         at_limit;

  assign at_limit = (idle_cnt == W'(FREE_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idle_cnt <= '0;
    else if (bsy_in)     idle_cnt <= '0;
    else if (!at_limit)  idle_cnt <= idle_cnt + 1'b1;
  end

  assign bus_free = at_limit;

  // R3: an active BSY sample clears the free indication.
  assert_busy_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_in |=> !bus_free);

  // R2: the count never passes its limit.
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= W'(FREE_CYC));
endmodule

// File: rtl/arb_delay_timer.sv
module arb_delay_timer #(
  parameter int unsigned DELAY_CYC = 550
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int unsigned W = scsi_arb_pkg::cnt_width(DELAY_CYC);

  logic [W-1:0] tick;

  assign expire = run && (tick == W'(DELAY_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tick <= '0;
    else if (!run)    tick <= '0;
    else if (!expire) tick <= tick + 1'b1;
  end

  // R5: the timer stays inside its window.
  assert_timer_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= W'(DELAY_CYC - 1));

  // R5: the count restarts from zero whenever the timer is idle.
  assert_timer_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> tick == '0);
endmodule

// File: rtl/scsi_arb_filter.sv
module scsi_arb_filter #(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned FREE_NS       = 1200,
  parameter int unsigned ARB_DELAY_NS  = 2200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bsy_in,
  input  logic sel_in,
  input  logic arb_req,
  output logic bsy_drive,
  output logic bus_free,
  output logic arb_in_progress,
  output logic arb_sample_ok,
  output logic arb_lost
);
  import scsi_arb_pkg::*;

  localparam int unsigned FREE_CYC  = ns_to_cycles(FREE_NS, CLK_PERIOD_PS);
  localparam int unsigned DELAY_CYC = ns_to_cycles(ARB_DELAY_NS, CLK_PERIOD_PS);

  arb_state_e state, state_nx;
  logic       lost_q;

  // Named internal events.
  logic start_arb;
  logic wait_done;
  logic release_arb;
  logic sel_in_wait;

  arb_bus_free_filter #(.FREE_CYC(FREE_CYC)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .bsy_in   (bsy_in),
    .bus_free (bus_free)
  );

  arb_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state == ARB_WAIT),
    .expire (wait_done)
  );

  assign release_arb = !arb_req;
  assign start_arb   = (state == ARB_IDLE) && arb_req && bus_free && !sel_in;
  assign sel_in_wait = (state == ARB_WAIT) && arb_req && sel_in;

  always_comb begin
    state_nx = state;
    if (release_arb) begin
      state_nx = ARB_IDLE;
    end else begin
      case (state)
        ARB_IDLE:   if (start_arb) state_nx = ARB_WAIT;
        ARB_WAIT:   if (wait_done) state_nx = ARB_SAMPLE;
        ARB_SAMPLE: state_nx = ARB_SAMPLE;
        default:    state_nx = ARB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ARB_IDLE;
      lost_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (release_arb)      lost_q <= 1'b0;
      else if (sel_in_wait) lost_q <= 1'b1;
    end
  end

  assign bsy_drive       = (state != ARB_IDLE);
  assign arb_in_progress = (state == ARB_WAIT);
  assign arb_sample_ok   = (state == ARB_SAMPLE);
  assign arb_lost        = lost_q;

  // R4: BSY is only taken when all three start conditions were met.
  assert_start_conditions_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_drive) |-> ($past(arb_req) && $past(bus_free) && !$past(sel_in)));

  // R6: a dropped request empties every status output on the next cycle.
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_req |=> (!bsy_drive && !arb_lost && !arb_sample_ok));

  // R7: SEL seen during the wait latches the lost flag.
  assert_lost_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_in_progress && arb_req && sel_in) |=> arb_lost);

  // R5: the sampling state is only reached from the wait.
  assert_sample_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_sample_ok) |-> $past(arb_in_progress));

  // R8: the two phases are exclusive and BSY covers both.
  assert_phase_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_in_progress, arb_sample_ok}) &&
    (bsy_drive == (arb_in_progress || arb_sample_ok)));
endmodule

// File: tb/scsi_arb_filter_bench.sv
module scsi_arb_filter_bench;
  localparam int PERIOD_PS = 4000;
  // The bench works out the cycle counts for itself: the time in ps divided by
  // the period, plus one more cycle if there is a remainder.
  localparam int FREE_N  = (1200 * 1000) / PERIOD_PS + (((1200 * 1000) % PERIOD_PS) != 0 ? 1 : 0);
  localparam int DELAY_N = (2200 * 1000) / PERIOD_PS + (((2200 * 1000) % PERIOD_PS) != 0 ? 1 : 0);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bsy_in = 1'b1, sel_in = 1'b0, arb_req = 1'b0;
  logic bsy_drive, bus_free, arb_in_progress, arb_sample_ok, arb_lost;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  // Reference model state.
  int m_quiet = 0;   // cycles of BSY inactivity seen
  int m_phase = 0;   // 0 idle, 1 waiting, 2 sampling
  int m_wait  = 0;   // cycles spent waiting
  bit m_lost  = 0;

  always #2ns clk = ~clk;

  scsi_arb_filter u_scsi_arb_filter (
    .clk(clk), .rst_n(rst_n), .bsy_in(bsy_in), .sel_in(sel_in), .arb_req(arb_req),
    .bsy_drive(bsy_drive), .bus_free(bus_free), .arb_in_progress(arb_in_progress),
    .arb_sample_ok(arb_sample_ok), .arb_lost(arb_lost)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      bit was_free;
      was_free = (m_quiet >= FREE_N);
      if (!arb_req) begin
        m_phase = 0; m_lost = 0; m_wait = 0;
      end else if (m_phase == 0) begin
        if (was_free && !sel_in) begin m_phase = 1; m_wait = 0; end
      end else if (m_phase == 1) begin
        if (sel_in) m_lost = 1;
        m_wait++;
        if (m_wait == DELAY_N) m_phase = 2;
      end
      if (bsy_in) m_quiet = 0; else m_quiet++;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check("R2/R3", "bus_free",        bus_free,        m_quiet >= FREE_N);
      check("R4",    "bsy_drive",       bsy_drive,       m_phase != 0);
      check("R5",    "arb_in_progress", arb_in_progress, m_phase == 1);
      check("R5",    "arb_sample_ok",   arb_sample_ok,   m_phase == 2);
      check("R7",    "arb_lost",        arb_lost,        m_lost);
    end
    if (cycles > 200000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    // R1: outputs during reset.
    check("R1", "bsy_drive in reset", bsy_drive, 1'b0);
    check("R1", "bus_free in reset", bus_free, 1'b0);
    check("R1", "arb_lost in reset", arb_lost, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    check("R1", "arb_sample_ok after reset", arb_sample_ok, 1'b0);
    check("R1", "arb_in_progress after reset", arb_in_progress, 1'b0);
    bsy_in = 1'b0;
    // R4: request before the bus is free does nothing.
    arb_req = 1'b1;
    cyc(200);
    // R3: a one-cycle BSY pulse restarts the filter.
    bsy_in = 1'b1; cyc(1); bsy_in = 1'b0;
    cyc(FREE_N - 1);
    // R4: SEL held active blocks the start once the bus is free.
    sel_in = 1'b1;
    cyc(10);
    sel_in = 1'b0;
    // R5: full wait, then the sampling state.
    cyc(DELAY_N + 20);
    // R6: release.
    arb_req = 1'b0; cyc(5);
    // R7: SEL in the middle of the wait.
    arb_req = 1'b1; cyc(100);
    sel_in = 1'b1; cyc(1); sel_in = 1'b0;
    cyc(DELAY_N);
    // R7: SEL during sampling leaves the flag as it is.
    sel_in = 1'b1; cyc(2); sel_in = 1'b0;
    arb_req = 1'b0; cyc(3);
    // R7: SEL sampled on the same edge the delay expires.
    arb_req = 1'b1;
    cyc(DELAY_N);
    sel_in = 1'b1; cyc(1); sel_in = 1'b0;
    cyc(5);
    arb_req = 1'b0; cyc(2);
    // R6: release in the same cycle as SEL during the wait.
    arb_req = 1'b1; cyc(50);
    arb_req = 1'b0; sel_in = 1'b1; cyc(1); sel_in = 1'b0;
    cyc(3);
    // R3: BSY from others while waiting clears bus_free only.
    arb_req = 1'b1; cyc(30);
    bsy_in = 1'b1; cyc(4); bsy_in = 1'b0;
    cyc(DELAY_N + 10);
    arb_req = 1'b0; cyc(10);
    finish_run();
  end
endmodule